// File: doc/BRIEF.md
# Edge-Selective Programmable Delay Timer

This block holds back selected transitions of one logic input and forwards them to a single registered output. The delay is a whole number of master timebase ticks. A 4-bit configuration code, already in digital form, sets the delay. A free-running clock paces the logic, and a separate tick enable marks the master timebase periods that are counted. When tick stays low, the timebase is halted and any delay in progress is frozen.

The code decodes into two things: a divide ratio taken from a set of powers of two, and a polarity bit. The polarity bit is the top bit of the code. The codes in the upper half select the same ratios as the lower half, in reverse order. A parameter picks one of two variants. In the edge-select variant, only the edge direction chosen by the polarity bit is delayed, and the other direction goes straight through. In the inverting variant, both edge directions are delayed, and the polarity bit inverts the output. In both variants, an input that returns to its old level before the delay ends is treated as a glitch and is filtered out.

Top module: `edge_delay_timer`

## Requirements
- R1: The divide ratio is N = 2^(LOG_STEP*i). The index i is code[2:0] when code[3]=0, and 7-code[2:0] when code[3]=1. With the default LOG_STEP=3 this gives ratios from 1 up to 2^21.
- R2: A delayed transition is first sampled on some clock edge. It appears at dout on the N-th later clock edge at which tick is high.
- R3: In the edge-select variant (VARIANT=0), the polarity bit code[3] selects which edge is delayed. A value of 0 delays rising edges, and a value of 1 delays falling edges.
- R4: In the edge-select variant, a transition that is not delayed reaches dout on the same clock edge that samples it.
- R5: In the inverting variant (VARIANT=1), both edge directions are delayed by N ticks, and dout equals the internal level XOR code[3].
- R6: If din returns to the output level before the count ends, the pending transition is dropped and dout does not change.
- R7: While tick is low, a pending delay does not advance and dout holds its value.
- R8: The code is captured when a delay starts. A code change while the delay runs does not change its length or polarity.
- R9: Synchronous reset clears dout to 0 and cancels any pending delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Master timebase enable; low halts the count |
| din | input | 1 | Data input whose edges are delayed |
| code | input | 4 | Configuration code: ratio index and polarity bit |
| dout | output | 1 | Registered delayed output |

## Verification
A wrong internal state shows up directly as a wrong edge time or a missing edge at dout:
- A count register that is off by one moves the output edge by one clock for every code.
- A mirrored index decoded the wrong way gives the wrong latency for every upper-half code.
- A stale busy flag either swallows a later edge or lets a glitch through, and this is visible within one delay length.

The sweep measures the exact latency of both edge directions for every code in both variants. This places every such fault within at most 2^(7*LOG_STEP)+1 clocks of the stimulus.

// File: rtl/edt_pkg.sv
package edt_pkg;
  // Ratio index: lower half ascending, upper half mirrored.
  function automatic logic [2:0] ratio_index(input logic [3:0] c);
    return c[3] ? ~c[2:0] : c[2:0];
  endfunction
endpackage

// File: rtl/edt_cfg_decode.sv
module edt_cfg_decode #(
  parameter int LOG_STEP = 3,
  parameter int CNT_W    = LOG_STEP*7+1
) (
  input  logic [3:0]       code,
  output logic [CNT_W-1:0] last,
  output logic             pol
);
  import edt_pkg::*;
  logic [2:0] idx;
  always_comb begin
    idx  = ratio_index(code);
    last = (CNT_W'(1) << (LOG_STEP*int'(idx))) - CNT_W'(1);
    pol  = code[3];
  end
endmodule

// File: rtl/edt_delay_counter.sv
module edt_delay_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  assign hit = (cnt == last);
  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (en && !hit) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/edge_delay_timer.sv
module edge_delay_timer #(
  parameter int VARIANT  = 0,
  parameter int LOG_STEP = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       din,
  input  logic [3:0] code,
  output logic       dout
);
  localparam int CNT_W = LOG_STEP*7+1;

  logic             busy, lvl, lvl_nxt;
  logic [3:0]       cfg_q, cfg_sel;
  logic [CNT_W-1:0] cnt, last;
  logic             pol, hit, inv;
  logic             delay_this, start, bypass, cancel, finish;

  assign cfg_sel = busy ? cfg_q : code;

  edt_cfg_decode #(.LOG_STEP(LOG_STEP), .CNT_W(CNT_W)) u_dec (
    .code(cfg_sel), .last(last), .pol(pol)
  );

  generate
    if (VARIANT == 0) begin : g_edge_sel
      assign delay_this = (din != pol);
      assign inv        = 1'b0;
    end else begin : g_invert
      assign delay_this = 1'b1;
      assign inv        = pol;
    end
  endgenerate

  assign start   = !busy && (din != lvl) && delay_this;
  assign bypass  = !busy && (din != lvl) && !delay_this;
  assign cancel  = busy && (din == lvl);
  assign finish  = busy && !cancel && tick && hit;
  assign lvl_nxt = (bypass || finish) ? din : lvl;

  edt_delay_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(start), .en(busy && tick),
    .last(last), .cnt(cnt), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      lvl   <= 1'b0;
      cfg_q <= '0;
      dout  <= 1'b0;
    end else begin
      if (!busy) cfg_q <= code;
      busy <= start || (busy && !cancel && !finish);
      lvl  <= lvl_nxt;
      dout <= lvl_nxt ^ inv;
    end
  end
endmodule

// File: rtl/edge_delay_timer_chk.sv
module edge_delay_timer_chk #(
  parameter int VARIANT  = 0,
  parameter int LOG_STEP = 3,
  parameter int CNT_W    = LOG_STEP*7+1
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             din,
  input logic [3:0]       code,
  input logic             dout,
  input logic             busy,
  input logic             lvl,
  input logic [3:0]       cfg_q,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] last
);
  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk)
    if (rst_seen)
      AST_RESET_IDLE: assert (!dout && !busy); // R9

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= last)); // R2

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(dout)); // R7

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(cfg_q))); // R8

  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (VARIANT == 0 && !busy && din != lvl && din == code[3]) |=> (dout == $past(din))); // R4
endmodule

bind edge_delay_timer edge_delay_timer_chk #(
  .VARIANT(VARIANT), .LOG_STEP(LOG_STEP), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_edge_delay_timer.sv
module tb_edge_delay_timer;
  localparam int STEP = 1;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b1, din = 1'b0;
  logic [3:0] code = 4'd0;
  logic dout0, dout1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_delay_timer #(.VARIANT(0), .LOG_STEP(STEP)) dut (
    .clk(clk), .rst(rst), .tick(tick), .din(din), .code(code), .dout(dout0));
  edge_delay_timer #(.VARIANT(1), .LOG_STEP(STEP)) dut_inv (
    .clk(clk), .rst(rst), .tick(tick), .din(din), .code(code), .dout(dout1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Change din and record the edge count until each output moves.
  task automatic run_edge(input logic v, input int win, output int l0, output int l1);
    logic o0, o1;
    o0 = dout0; o1 = dout1; l0 = 0; l1 = 0;
    din = v;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (l0 == 0 && dout0 != o0) l0 = i;
      if (l1 == 0 && dout1 != o1) l1 = i;
    end
  endtask

  initial begin
    int l0, l1, n, e0, e1;
    logic p;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    check(dout0 == 1'b0, "R9 reset dout edge", dout0, 0);
    check(dout1 == 1'b0, "R9 reset dout inv", dout1, 0);

    // Sweep every code, both edges, both variants.
    for (int c = 0; c < 16; c++) begin
      code = 4'(c);
      p = code[3];
      n = 1 << (STEP * (p ? 7 - (c & 7) : (c & 7)));
      cycles(3);
      check(dout1 == p, "R5 idle inversion", dout1, p);
      run_edge(1'b1, 200, l0, l1);
      e0 = p ? 1 : n + 1;
      check(l0 == e0, p ? "R4 rising bypass" : "R1 R2 R3 rising delay", l0, e0);
      check(l1 == n + 1, "R1 R5 inv rising delay", l1, n + 1);
      check(dout1 == (1'b1 ^ p), "R5 inv level high", dout1, 1 ^ p);
      run_edge(1'b0, 200, l0, l1);
      e0 = p ? n + 1 : 1;
      check(l0 == e0, p ? "R1 R2 R3 falling delay" : "R4 falling bypass", l0, e0);
      check(l1 == n + 1, "R1 R5 inv falling delay", l1, n + 1);
      check(dout1 == p, "R5 inv level low", dout1, p);
    end

    // R7: halted timebase freezes the count.
    code = 4'd2; cycles(3);
    din = 1'b1; tick = 1'b0;
    cycles(20);
    check(dout0 == 1'b0, "R7 halt holds edge", dout0, 0);
    check(dout1 == 1'b0, "R7 halt holds inv", dout1, 0);
    tick = 1'b1;
    run_edge(1'b1, 40, l0, l1);
    check(l0 == 4, "R7 resume count edge", l0, 4);
    check(l1 == 4, "R7 resume count inv", l1, 4);
    din = 1'b0; cycles(20);

    // R8: a code change during a delay is ignored.
    code = 4'd4; cycles(3);
    din = 1'b1; cycles(1);
    code = 4'd0;
    run_edge(1'b1, 60, l0, l1);
    check(l0 == 16, "R8 locked length edge", l0, 16);
    check(l1 == 16, "R8 locked length inv", l1, 16);
    din = 1'b0; cycles(40);

    // R6: short pulse is filtered.
    code = 4'd3; cycles(3);
    din = 1'b1; cycles(3); din = 1'b0;
    cycles(30);
    check(dout0 == 1'b0, "R6 pulse filtered edge", dout0, 0);
    check(dout1 == 1'b0, "R6 pulse filtered inv", dout1, 0);

    // R6 with falling polarity in the edge-select variant.
    code = 4'd12; cycles(3);
    din = 1'b1; cycles(20);
    check(dout0 == 1'b1, "R4 rising bypass pol1", dout0, 1);
    check(dout1 == 1'b0, "R5 inverted high", dout1, 0);
    din = 1'b0; cycles(2); din = 1'b1;
    cycles(30);
    check(dout0 == 1'b1, "R6 low glitch filtered edge", dout0, 1);
    check(dout1 == 1'b0, "R6 low glitch filtered inv", dout1, 0);

    // R9: reset during a pending delay.
    din = 1'b0; code = 4'd5; cycles(20);
    din = 1'b1; cycles(4);
    rst = 1'b1; cycles(2); din = 1'b0; rst = 1'b0;
    cycles(60);
    check(dout0 == 1'b0, "R9 reset cancels edge", dout0, 0);
    check(dout1 == 1'b0, "R9 reset cancels inv", dout1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule